// File: doc/BRIEF.md
# Ring Capture Stop Controller

This block supervises a sample memory that writes without pause into a ring. Arming starts capture and holds the memory selected. The memory cannot report where it is writing, so the block keeps its own copy of the write position. That copy is a group address that advances once every four samples, plus a sub-count of the sample position inside the current eight-sample byte.

A trigger loads a down-counter with the number of post-trigger sample groups. Each group is four samples. The down-counter counts toward zero and starts on the sample edge after the trigger. Once it reaches zero, the block waits for the next byte end, deselects the memory and raises done. It then presents the group address where readout must begin so that the oldest stored sample comes out first.

Sample numbering below counts the rising clock edges after the arming edge. Sample 0 is the cycle that directly follows the edge at which arm was seen. A sample's edge is the edge that closes that cycle.

Top module: `cap_ring_ctrl`

## Requirements
- R1: After reset, mem_cs_n is 1, done is 0 and rd_start is 0.
- R2: When arm is high at an edge, from the next cycle mem_cs_n is 0 and done is 0, and sample numbering restarts at 0. This holds in the idle, capturing and done states alike.
- R3: While capturing with no trigger seen, mem_cs_n stays 0 for any number of samples, past any number of ring wraps.
- R4: A trigger that is high at the edge of sample t loads post_cnt as a count of 4-sample groups. The count drops by one at each edge of a sample with index mod 4 equal to 3 and index greater than t, and stops at zero.
- R5: Once the count is zero, capture halts at the edge of the first later sample whose index mod 8 equals 7. From the next cycle mem_cs_n is 1 and done is 1.
- R6: With post_cnt equal to 0, the halt comes at the first sample after t whose index mod 8 is 7. If t itself has index mod 8 equal to 7, the halt comes eight samples later.
- R7: After the halt, rd_start equals (b div 4 + 1) mod 2^CNT_W, where b is the index of the last stored sample.
- R8: Trigger pulses after the first one in a capture are ignored, and so are triggers while idle or done.
- R9: done stays 1 and rd_start stays unchanged until the next arm.
- R10: post_cnt is sampled only at the trigger edge. Later changes do not move the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start or restart ring capture |
| trig | input | 1 | Trigger condition from the matcher |
| post_cnt | input | CNT_W | Post-trigger length in 4-sample groups |
| mem_cs_n | output | 1 | Memory select, low while recording |
| done | output | 1 | Capture halted, readout address valid |
| rd_start | output | CNT_W | Group address of the oldest sample |

## Verification
The hardest situation to reach is a halt whose final group address has wrapped the ring more than once, combined with a trigger that lands at the very end of a byte while the post count is zero. The bench builds the controller with a small group-address width so that a few hundred samples wrap the ring. It places triggers both at directed byte-end indices and at random indices well past several wraps. Extra trigger pulses and post_cnt changes are mixed in after the first trigger. In every case the bench predicts the halt sample arithmetically, from the group-end and byte-end rules.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_DONE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cap_ring_pos.sv
module cap_ring_pos #(
    parameter int CNT_W     = 16,
    parameter int GRP_LOG2  = 2,
    parameter int BYTE_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 run,
    output logic [BYTE_LOG2-1:0] sub_o,
    output logic [CNT_W-1:0]     addr_o,
    output logic                 grp_end,
    output logic                 byte_end
);
    typedef struct packed {
        logic [BYTE_LOG2-1:0] sub;
        logic [CNT_W-1:0]     addr;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        grp_end  = run && (&pos_q.sub[GRP_LOG2-1:0]);
        byte_end = run && (&pos_q.sub);
        pos_d    = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (run) begin
            pos_d.sub = pos_q.sub + 1'b1;
            if (grp_end) begin
                pos_d.addr = pos_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign sub_o  = pos_q.sub;
    assign addr_o = pos_q.addr;
endmodule

// File: rtl/cap_post_down.sv
module cap_post_down #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        zero  = (cnt_q == '0);
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && !zero) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl
    import cap_ring_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int GRP_LOG2  = 2,
    parameter int BYTE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig,
    input  logic [CNT_W-1:0] post_cnt,
    output logic             mem_cs_n,
    output logic             done,
    output logic [CNT_W-1:0] rd_start
);
    typedef struct packed {
        cap_state_e       st;
        logic             seen;
        logic [CNT_W-1:0] start;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 run;
    logic                 fire;
    logic                 halt;
    logic                 grp_end;
    logic                 byte_end;
    logic                 cnt_zero;
    logic [BYTE_LOG2-1:0] sub_w;
    logic [CNT_W-1:0]     addr_w;

    cap_ring_pos #(
        .CNT_W    (CNT_W),
        .GRP_LOG2 (GRP_LOG2),
        .BYTE_LOG2(BYTE_LOG2)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (arm),
        .run     (run),
        .sub_o   (sub_w),
        .addr_o  (addr_w),
        .grp_end (grp_end),
        .byte_end(byte_end)
    );

    cap_post_down #(
        .CNT_W(CNT_W)
    ) u_down (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fire),
        .load_val(post_cnt),
        .step    (grp_end),
        .zero    (cnt_zero)
    );

    always_comb begin
        run   = (ctl_q.st == ST_CAPT) && !arm;
        fire  = run && !ctl_q.seen && trig;
        halt  = run && ctl_q.seen && cnt_zero && byte_end;
        ctl_d = ctl_q;
        if (arm) begin
            ctl_d.st   = ST_CAPT;
            ctl_d.seen = 1'b0;
        end else if (halt) begin
            ctl_d.st    = ST_DONE;
            ctl_d.start = addr_w + 1'b1;
        end else if (fire) begin
            ctl_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.seen  <= 1'b0;
            ctl_q.start <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_cs_n = (ctl_q.st != ST_CAPT);
    assign done     = (ctl_q.st == ST_DONE);
    assign rd_start = ctl_q.start;
endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
    parameter int CNT_W     = 16,
    parameter int BYTE_LOG2 = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 arm,
    input logic                 mem_cs_n,
    input logic                 done,
    input logic [CNT_W-1:0]     rd_start,
    input logic [BYTE_LOG2-1:0] sub,
    input logic [CNT_W-1:0]     addr
);
    assert_arm_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!mem_cs_n && !done));

    assert_halt_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> ($past(sub) == {BYTE_LOG2{1'b1}}));

    assert_start_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (rd_start == CNT_W'($past(addr) + 1'b1)));

    assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    assert_start_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(rd_start));
endmodule

bind cap_ring_ctrl cap_ring_chk #(
    .CNT_W    (CNT_W),
    .BYTE_LOG2(BYTE_LOG2)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .mem_cs_n(mem_cs_n),
    .done    (done),
    .rd_start(rd_start),
    .sub     (sub_w),
    .addr    (addr_w)
);

// File: tb/sim_cap_ring_ctrl.sv
`timescale 1ns/1ps
module sim_cap_ring_ctrl;
    localparam int CNT_W = 5;
    localparam int RING  = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic             trig = 1'b0;
    logic [CNT_W-1:0] post_cnt = '0;
    logic             mem_cs_n;
    logic             done;
    logic [CNT_W-1:0] rd_start;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cap_ring_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
        .post_cnt(post_cnt), .mem_cs_n(mem_cs_n), .done(done), .rd_start(rd_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int halt_idx(input int t, input int n);
        int e = t;
        for (int i = 0; i < n; i++) e = (e + 1) | 3;
        return (e + 1) | 7;
    endfunction

    task automatic do_arm();
        arm = 1'b1;
        @(posedge clk); #1;
        arm = 1'b0;
        chk("R2 cs_n after arm", int'(mem_cs_n), 0);
        chk("R2 done after arm", int'(done), 0);
    endtask

    task automatic run_case(input int t, input int n, input bit noise);
        int b;
        int exp_start;
        int held;
        string tag;
        tag = (n == 0) ? "R6" : "R5";
        do_arm();
        post_cnt = CNT_W'(n);
        b = halt_idx(t, n);
        exp_start = ((b >> 2) + 1) % RING;
        for (int s = 0; s <= b + 2; s++) begin
            trig = (s == t) || (noise && s > t && ($urandom % 3 == 0));
            if (s > t) post_cnt = CNT_W'($urandom); // R10
            @(posedge clk); #1;
            trig = 1'b0;
            if (s >= b - 1) begin
                chk({tag, " R4 cs_n at halt"}, int'(mem_cs_n), (s >= b) ? 1 : 0);
                chk({tag, " done at halt"}, int'(done), (s >= b) ? 1 : 0);
            end else if (mem_cs_n !== 1'b0) begin
                chk({tag, " R8 R10 early halt"}, int'(mem_cs_n), 0);
            end
        end
        chk("R7 rd_start", int'(rd_start), exp_start);
        held = int'(rd_start);
        trig = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        trig = 1'b0;
        chk("R8 R9 done held after trig", int'(done), 1);
        chk("R9 rd_start held", int'(rd_start), held);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        #1;
        chk("R1 cs_n reset", int'(mem_cs_n), 1);
        chk("R1 done reset", int'(done), 0);
        chk("R1 rd_start reset", int'(rd_start), 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 cs_n after release", int'(mem_cs_n), 1);

        trig = 1'b1;
        repeat (3) @(posedge clk);
        #1 trig = 1'b0;
        chk("R8 idle trig cs_n", int'(mem_cs_n), 1);
        chk("R8 idle trig done", int'(done), 0);

        do_arm();
        for (int s = 0; s < 10 * RING * 4; s++) begin
            @(posedge clk); #1;
            if (mem_cs_n !== 1'b0 || done !== 1'b0) chk("R3 ring keeps running", int'(mem_cs_n), 0);
        end
        chk("R3 still selected after wraps", int'(mem_cs_n), 0);

        run_case(0, 0, 1'b0);
        run_case(7, 0, 1'b0);
        run_case(6, 0, 1'b1);
        run_case(5, 1, 1'b0);
        run_case(3, 31, 1'b1);
        run_case(300, 31, 1'b1);
        run_case(131, 2, 1'b1);

        do_arm();
        post_cnt = CNT_W'(31);
        for (int s = 0; s < 20; s++) begin
            trig = (s == 2);
            @(posedge clk); #1;
            trig = 1'b0;
        end
        run_case(9, 2, 1'b0); // R2 re-arm mid capture

        for (int k = 0; k < 25; k++) begin
            run_case(int'($urandom % 400), int'($urandom % RING), 1'b1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule